// File: doc/BRIEF.md
# Synthesizer Serial Power-Up Loader

After each reset this block programs an external frequency-synthesizer device over a three-wire serial link: a select line, a serial clock and a data line. It sends three frames, always in the same order. The first is a fixed 8-bit setup byte. The second is a fixed 15-bit reference-divider value. The third is a 16-bit main-divider value, equal to a fixed base count plus an 8-bit channel number taken from an input port. It then raises a done flag and leaves the link idle until the next reset.

The serial clock is derived from the system clock. Each serial-clock high phase and low phase lasts `HALF_DIV` system clocks, set by a parameter. The select line is held low while a frame's bits are shifted, and is pulled high afterwards so the target latches the frame. With the default constants, the main divider starts at 876, so channel 0 selects the bottom of the band and each channel step adds one divider count.

Top module: `pll_ldr`

## Requirements
- R1: After reset, exactly three frames are sent, in this order and with these lengths: 8 bits, then 15 bits, then 16 bits.
- R2: The first frame carries the setup byte 0x64.
- R3: The second frame carries the reference divider 40 (0x0028) as a 15-bit value.
- R4: The third frame carries 0x036C plus the unsigned 8-bit `chan_sel`. The sum is formed over 16 bits, so a carry out of the low byte reaches the high byte (for example 0x93 gives 0x03FF and 0x94 gives 0x0400).
- R5: Every frame is sent most-significant bit first.
- R6: `syn_en` is low for the whole of a frame's shifting. It rises after the frame's last bit to latch the frame, and `syn_clk` never pulses while `syn_en` is high.
- R7: `syn_clk` idles low. `syn_data` changes only in a cycle where `syn_clk` is low, and never in the cycle where `syn_clk` rises.
- R8: `syn_en` is high during reset and after it. Before every frame, `syn_en` stays high for at least `HALF_DIV` system clocks before it falls.
- R9: `chan_sel` is captured once, in the cycle where `syn_en` falls for the third frame. Later changes to it have no effect on the frame being sent.
- R10: `done` is low until the third frame has been latched and then stays high. After that, `syn_en` stays high, `syn_clk` stays low and no further frame is sent until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts a new load sequence |
| chan_sel | input | 8 | Channel number added to the base main-divider count |
| syn_en | output | 1 | Serial select; low while shifting, rising edge latches a frame |
| syn_clk | output | 1 | Serial clock; the target samples data on its rising edge |
| syn_data | output | 1 | Serial data, sent MSB first |
| done | output | 1 | High once all three frames have been latched |

## Verification
The bench decodes the link the way the target does: it shifts in data on each rising edge of `syn_clk` while `syn_en` is low, and closes a frame on each rising edge of `syn_en`. It then compares the order, length and value of every frame.

Channel values on both sides of the low-byte carry (0x93 and 0x94) and at the top of the range (0xFF) catch an adder that drops the carry into the high byte. Any such adder yields a main divider that is 256 too small. Changing `chan_sel` in the middle of the third frame catches a design that reads the input live; that design would emit a mixed word. Watching the link long after `done` catches a sequencer that wraps around and reprograms the device, or leaves a clock pulse on the line after the final latch.

// File: rtl/pll_ldr_pkg.sv
package pll_ldr_pkg;
    localparam int WORD_W    = 16;
    localparam int BITCNT_W  = $clog2(WORD_W);
    localparam int FRAME_CNT = 3;

    typedef enum logic [1:0] {
        PH_GAP,     // select high, waiting before the next frame
        PH_SETUP,   // clock low, data presented
        PH_HIGH,    // clock high, target samples
        PH_TAIL     // clock low after last bit, then latch
    } phase_e;

    typedef struct packed {
        phase_e                 ph;
        logic [1:0]             frame;
        logic [BITCNT_W-1:0]    bits_left;
        logic [WORD_W-1:0]      shreg;
        logic                   sclk;
        logic                   sen;
        logic                   sdata;
        logic                   done;
    } ldr_state_t;
endpackage

// File: rtl/pll_ldr_tick.sv
module pll_ldr_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        tick  = (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pll_ldr_frames.sv
module pll_ldr_frames
    import pll_ldr_pkg::*;
#(
    parameter logic [7:0]        SETUP_WORD = 8'h64,
    parameter logic [WORD_W-1:0] REF_DIV    = 16'h0028,
    parameter int                REF_LEN    = 15,
    parameter logic [WORD_W-1:0] MAIN_BASE  = 16'h036C,
    parameter int                CH_W       = 8
) (
    input  logic [1:0]          idx,
    input  logic [CH_W-1:0]     chan,
    output logic [WORD_W-1:0]   word,
    output logic [BITCNT_W-1:0] last_bit
);
    logic [WORD_W-1:0] main_sum;

    always_comb begin
        main_sum = MAIN_BASE + WORD_W'(chan);
        case (idx)
            2'd0: begin
                word     = {SETUP_WORD, {(WORD_W-8){1'b0}}};
                last_bit = BITCNT_W'(7);
            end
            2'd1: begin
                word     = REF_DIV << (WORD_W - REF_LEN);
                last_bit = BITCNT_W'(REF_LEN - 1);
            end
            default: begin
                word     = main_sum;
                last_bit = BITCNT_W'(WORD_W - 1);
            end
        endcase
    end
endmodule

// File: rtl/pll_ldr.sv
module pll_ldr
    import pll_ldr_pkg::*;
#(
    parameter int                HALF_DIV   = 4,
    parameter logic [7:0]        SETUP_WORD = 8'h64,
    parameter logic [WORD_W-1:0] REF_DIV    = 16'h0028,
    parameter int                REF_LEN    = 15,
    parameter logic [WORD_W-1:0] MAIN_BASE  = 16'h036C,
    parameter int                CH_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_W-1:0] chan_sel,
    output logic            syn_en,
    output logic            syn_clk,
    output logic            syn_data,
    output logic            done
);
    localparam logic [1:0] LAST_FRAME = 2'(FRAME_CNT);

    ldr_state_t s_d, s_q;
    logic                tick;
    logic [WORD_W-1:0]   fr_word;
    logic [BITCNT_W-1:0] fr_last;

    pll_ldr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pll_ldr_frames #(
        .SETUP_WORD (SETUP_WORD),
        .REF_DIV    (REF_DIV),
        .REF_LEN    (REF_LEN),
        .MAIN_BASE  (MAIN_BASE),
        .CH_W       (CH_W)
    ) u_frames (
        .idx      (s_q.frame),
        .chan     (chan_sel),
        .word     (fr_word),
        .last_bit (fr_last)
    );

    always_comb begin
        s_d = s_q;
        if (tick) begin
            case (s_q.ph)
                PH_GAP: begin
                    if (s_q.frame == LAST_FRAME) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.sen       = 1'b0;
                        s_d.shreg     = fr_word;
                        s_d.sdata     = fr_word[WORD_W-1];
                        s_d.bits_left = fr_last;
                        s_d.ph        = PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    s_d.sclk = 1'b1;
                    s_d.ph   = PH_HIGH;
                end
                PH_HIGH: begin
                    s_d.sclk = 1'b0;
                    if (s_q.bits_left == '0) begin
                        s_d.ph = PH_TAIL;
                    end else begin
                        s_d.shreg     = s_q.shreg << 1;
                        s_d.sdata     = s_q.shreg[WORD_W-2];
                        s_d.bits_left = s_q.bits_left - 1'b1;
                        s_d.ph        = PH_SETUP;
                    end
                end
                default: begin
                    s_d.sen   = 1'b1;
                    s_d.sdata = 1'b0;
                    s_d.frame = s_q.frame + 1'b1;
                    s_d.ph    = PH_GAP;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph        <= PH_GAP;
            s_q.frame     <= '0;
            s_q.bits_left <= '0;
            s_q.shreg     <= '0;
            s_q.sclk      <= 1'b0;
            s_q.sen       <= 1'b1;
            s_q.sdata     <= 1'b0;
            s_q.done      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign syn_en   = s_q.sen;
    assign syn_clk  = s_q.sclk;
    assign syn_data = s_q.sdata;
    assign done     = s_q.done;
endmodule

// File: rtl/pll_ldr_checker.sv
module pll_ldr_checker #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic syn_en,
    input logic syn_clk,
    input logic syn_data,
    input logic done
);
    logic [15:0] gap_cnt;
    logic [3:0]  latch_cnt;
    logic        en_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt   <= '0;
            latch_cnt <= '0;
            en_prev   <= 1'b1;
        end else begin
            en_prev <= syn_en;
            if (!syn_en)               gap_cnt <= '0;
            else if (gap_cnt != '1)    gap_cnt <= gap_cnt + 1'b1;
            if (syn_en && !en_prev && latch_cnt != '1) latch_cnt <= latch_cnt + 1'b1;
        end
    end

    // R6
    a_r6_clk_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        syn_clk |-> !syn_en);
    // R7
    a_r7_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(syn_data) |-> !syn_clk);
    a_r7_data_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_clk) |-> $stable(syn_data));
    // R8
    a_r8_gap_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(syn_en) |-> gap_cnt >= 16'(HALF_DIV));
    // R10
    a_r10_done_after_three: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> latch_cnt == 4'd3);
    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && syn_en && !syn_clk);
    // R1
    a_r1_no_fourth_frame: assert property (@(posedge clk) disable iff (!rst_n)
        latch_cnt <= 4'd3);
endmodule

bind pll_ldr pll_ldr_checker #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .syn_en   (syn_en),
    .syn_clk  (syn_clk),
    .syn_data (syn_data),
    .done     (done)
);

// File: tb/pll_ldr_tb.sv
`timescale 1ns/1ps
module pll_ldr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] chan_sel = 8'h00;
    logic       syn_en, syn_clk, syn_data, done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pll_ldr u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_sel (chan_sel),
        .syn_en   (syn_en),
        .syn_clk  (syn_clk),
        .syn_data (syn_data),
        .done     (done)
    );

    // Target-side decoder of the serial link
    logic [31:0] sh;
    int          nb, nfr, stray;
    logic [31:0] fval [3];
    int          flen [3];

    always @(posedge syn_clk) begin
        if (syn_en) stray++;
        else begin
            sh = {sh[30:0], syn_data};
            nb++;
        end
    end

    always @(posedge syn_en) begin
        if (nb > 0) begin
            if (nfr < 3) begin
                fval[nfr] = sh;
                flen[nfr] = nb;
            end
            nfr++;
        end
        nb = 0;
        sh = '0;
    end

    // channel, expected main divider
    localparam logic [23:0] VEC [6] = '{
        {8'h00, 16'h036C}, {8'h01, 16'h036D}, {8'h93, 16'h03FF},
        {8'h94, 16'h0400}, {8'hCC, 16'h0438}, {8'hFF, 16'h046B}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic start_run(input logic [7:0] ch);
        @(negedge clk);
        rst_n    = 1'b0;
        chan_sel = ch;
        repeat (3) @(negedge clk);
        sh = '0; nb = 0; nfr = 0; stray = 0;
        fval[0] = '0; fval[1] = '0; fval[2] = '0;
        flen[0] = 0;  flen[1] = 0;  flen[2] = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
        chk(done, "R10 done raised (watchdog)", 32'(done), 32'd1);
    endtask

    task automatic check_frames(input logic [15:0] exp_main);
        chk(nfr == 3, "R1 frame count", 32'(nfr), 32'd3);
        chk(flen[0] == 8 && flen[1] == 15 && flen[2] == 16, "R1 frame lengths",
            32'(flen[0] * 10000 + flen[1] * 100 + flen[2]), 32'd81516);
        chk(fval[0] == 32'h64, "R2 R5 setup byte", fval[0], 32'h64);
        chk(fval[1] == 32'h28, "R3 R5 reference divider", fval[1], 32'h28);
        chk(fval[2] == 32'(exp_main), "R4 R5 main divider", fval[2], 32'(exp_main));
        chk(stray == 0, "R6 clock pulse with select high", 32'(stray), 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Reset state
        repeat (2) @(negedge clk);
        chk(syn_en == 1'b1, "R8 select high in reset", 32'(syn_en), 32'd1);
        chk(syn_clk == 1'b0, "R7 clock low in reset", 32'(syn_clk), 32'd0);
        chk(done == 1'b0, "R10 done low in reset", 32'(done), 32'd0);

        // Vector table
        for (int v = 0; v < 6; v++) begin
            start_run(VEC[v][23:16]);
            repeat (3) @(negedge clk);
            chk(syn_en == 1'b1, "R8 select high after reset", 32'(syn_en), 32'd1);
            chk(done == 1'b0, "R10 done low while loading", 32'(done), 32'd0);
            wait_done();
            check_frames(VEC[v][15:0]);
        end

        // R9: change channel mid-way through the third frame
        start_run(8'h94);
        for (int i = 0; i < 5000 && !(nfr == 2 && !syn_en); i++) @(negedge clk);
        repeat (6) @(negedge clk);
        chan_sel = 8'h00;
        wait_done();
        chk(fval[2] == 32'h0400, "R9 channel captured at frame start", fval[2], 32'h0400);

        // R10: long idle after done
        repeat (300) @(negedge clk);
        chk(nfr == 3, "R10 no reprogramming after done", 32'(nfr), 32'd3);
        chk(done && syn_en && !syn_clk, "R10 idle link after done",
            {29'd0, done, syn_en, syn_clk}, 32'd6);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule